// File: doc/BRIEF.md
# Frame Airtime Calculator

This block works out how long a single data frame keeps the medium busy, in microseconds. A request carries the frame length in bytes, a rate index (0 to 11, with larger values clamped to 11), a flag that selects the short preamble, and a packet-type code. Indexes 0 to 3 are the four spread-spectrum (CCK) rates. Indexes 4 to 11 are OFDM rates. The block looks up the rate entry and runs a shared sequential restoring divider. It rounds the quotient up when the remainder is nonzero, then adds the fixed overheads of the chosen modulation.

The rate entries are 10, 20, 55, 110, 24, 36, 48, 72, 96, 144, 192, 216 for indexes 0 through 11. For CCK the entry is the bit rate in units of 100 kbit/s. For OFDM it is the number of data bits carried per 4 µs symbol.

Requests enter on a valid/ready port and results leave on a valid/ready port. Only one request is in flight at a time. `in_ready` is high only while the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Once `out_valid` rises, the result holds still until the consumer raises `out_ready`. The block returns to idle on the edge that completes that transfer. A consumer that keeps `out_ready` low stalls the block, and no new request is accepted meanwhile.

Top module: `airtime_calc`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A rate index above 11 gives the same result as index 11.
- R3: For indexes 0 to 3 the result is P + ceil(len*80 / entry), where P is 96 when `in_short_pre` is 1 and 192 when it is 0.
- R4: When len*80 is an exact multiple of the CCK entry, no round-up is applied (for example, 11 bytes at index 3 with a short preamble give 104).
- R5: For indexes 4 to 11 with `in_pkt` = 0 (OFDM-only band), the result is 20 + 4*ceil((len*8 + 22) / entry).
- R6: For indexes 4 to 11 with any nonzero `in_pkt` code (1 = CCK band, 2 = mixed band), the result is 6 larger than under R5.
- R7: For OFDM rates, `in_short_pre` has no effect on the result.
- R8: For CCK rates, `in_pkt` has no effect on the result.
- R9: `in_ready` is 0 from the acceptance edge until the result has been taken. Requests presented in that window are ignored, and the result belongs to the request that was accepted.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_dur` stays unchanged.
- R11: On the edge where `out_valid` and `out_ready` are both 1, `out_valid` falls and `in_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_len | input | LEN_W (12) | Frame length in bytes |
| in_rate | input | 4 | Rate index; values above 11 are clamped |
| in_short_pre | input | 1 | 1 selects the short CCK preamble |
| in_pkt | input | 2 | 0 = OFDM-only band, 1 = CCK band, 2 = mixed band |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_dur | output | DUR_W (16) | Frame airtime in µs |

## Verification
The bench targets the rounding boundary on both sides. It uses CCK lengths whose scaled bit count divides the 5.5 Mbit/s and 11 Mbit/s entries exactly, and others that miss by a small remainder. A design that rounds on the wrong condition is off by one µs on one of these groups. Zero-length and 4095-byte frames check the smallest result and the widest dividend, which catch a truncated divider or result width. Rate indexes 12 to 15 check the clamp, which a design that indexes past the table would get wrong. Paired runs that differ only in the preamble flag or only in the packet code show leakage between the two modulation paths. Junk requests sent while the block is busy, and results held under back-pressure, show whether a second request can corrupt the one in flight or whether the output moves before it is taken.

// File: rtl/airtime_pkg.sv
package airtime_pkg;
  localparam int IDX_W      = 4;
  localparam int RATE_W     = 8;
  localparam int IDX_TOP    = 11;
  localparam int CCK_TOP    = 3;

  localparam int T_PRE_SHORT = 96;
  localparam int T_PRE_LONG  = 192;
  localparam int T_OFDM_HDR  = 20;
  localparam int T_SYM_SHIFT = 2;
  localparam int T_SIG_EXT   = 6;
  localparam int CCK_SCALE   = 80;
  localparam int OFDM_PAD    = 22;

  localparam logic [1:0] PKT_OFDM_ONLY = 2'd0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_SHOW = 2'd2
  } calc_st_t;

  function automatic logic [RATE_W-1:0] rate_entry(input logic [IDX_W-1:0] i);
    logic [RATE_W-1:0] r;
    case (i)
      4'd0:    r = 8'd10;
      4'd1:    r = 8'd20;
      4'd2:    r = 8'd55;
      4'd3:    r = 8'd110;
      4'd4:    r = 8'd24;
      4'd5:    r = 8'd36;
      4'd6:    r = 8'd48;
      4'd7:    r = 8'd72;
      4'd8:    r = 8'd96;
      4'd9:    r = 8'd144;
      4'd10:   r = 8'd192;
      default: r = 8'd216;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/airtime_rate_lut.sv
module airtime_rate_lut
  import airtime_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [RATE_W-1:0] rate,
  output logic              is_cck
);
  logic [IDX_W-1:0] idx_c;

  always_comb begin
    idx_c  = (idx > IDX_W'(IDX_TOP)) ? IDX_W'(IDX_TOP) : idx;
    rate   = rate_entry(idx_c);
    is_cck = (idx_c <= IDX_W'(CCK_TOP));
  end
endmodule

// File: rtl/airtime_div.sv
module airtime_div #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic [NUM_W-1:0] quot,
  output logic [DEN_W-1:0] rem,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_W - 1);

  logic [DEN_W:0]   acc;
  logic [NUM_W-1:0] work;
  logic [DEN_W-1:0] den;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             last;

  logic [DEN_W:0]   shifted;
  logic             fits;
  logic [DEN_W:0]   acc_nxt;
  logic [NUM_W-1:0] work_nxt;

  always_comb begin
    shifted  = {acc[DEN_W-1:0], work[NUM_W-1]};
    fits     = (shifted >= {1'b0, den});
    acc_nxt  = fits ? (shifted - {1'b0, den}) : shifted;
    work_nxt = {work[NUM_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      work <= '0;
      den  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      last <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last;
      last <= 1'b0;
      if (run) begin
        acc  <= acc_nxt;
        work <= work_nxt;
        if (cnt == CNT_LAST) begin
          run  <= 1'b0;
          last <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start && !last) begin
        acc  <= '0;
        work <= dividend;
        den  <= divisor;
        cnt  <= '0;
        run  <= 1'b1;
      end
    end
  end

  assign quot = work;
  assign rem  = acc[DEN_W-1:0];
  assign busy = run | last;
endmodule

// File: rtl/airtime_calc.sv
module airtime_calc
  import airtime_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LEN_W-1:0] in_len,
  input  logic [IDX_W-1:0] in_rate,
  input  logic             in_short_pre,
  input  logic [1:0]       in_pkt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DUR_W-1:0] out_dur
);
  localparam int DIV_W = LEN_W + 7;
  localparam int SUM_W = DIV_W + 3;

  calc_st_t          st;
  logic [RATE_W-1:0] lut_rate;
  logic              lut_cck;
  logic [DIV_W-1:0]  len_ext;
  logic [DIV_W-1:0]  dividend;
  logic              accept;

  logic [DIV_W-1:0]  div_quot;
  logic [RATE_W-1:0] div_rem;
  logic              div_busy;
  logic              div_done;

  logic              cck_q;
  logic              short_q;
  logic              ext_q;

  logic [DIV_W-1:0]  q_up;
  logic [SUM_W-1:0]  sum;
  logic [DUR_W-1:0]  dur_r;

  airtime_rate_lut u_lut (
    .idx    (in_rate),
    .rate   (lut_rate),
    .is_cck (lut_cck)
  );

  always_comb begin
    len_ext  = DIV_W'(in_len);
    dividend = lut_cck ? (len_ext * DIV_W'(CCK_SCALE))
                       : ((len_ext << 3) + DIV_W'(OFDM_PAD));
    accept   = in_valid && (st == ST_IDLE);
  end

  airtime_div #(.NUM_W(DIV_W), .DEN_W(RATE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .dividend (dividend),
    .divisor  (lut_rate),
    .quot     (div_quot),
    .rem      (div_rem),
    .busy     (div_busy),
    .done     (div_done)
  );

  always_comb begin
    q_up = div_quot + DIV_W'(div_rem != '0);
    if (cck_q) begin
      sum = SUM_W'(q_up) + SUM_W'(short_q ? T_PRE_SHORT : T_PRE_LONG);
    end else begin
      sum = (SUM_W'(q_up) << T_SYM_SHIFT) + SUM_W'(T_OFDM_HDR)
            + SUM_W'(ext_q ? T_SIG_EXT : 0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cck_q   <= 1'b0;
      short_q <= 1'b0;
      ext_q   <= 1'b0;
      dur_r   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cck_q   <= lut_cck;
          short_q <= in_short_pre;
          ext_q   <= (in_pkt != PKT_OFDM_ONLY);
          st      <= ST_CALC;
        end
        ST_CALC: if (div_done) begin
          dur_r <= DUR_W'(sum);
          st    <= ST_SHOW;
        end
        ST_SHOW: if (out_ready) begin
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_SHOW);
  assign out_dur   = dur_r;
endmodule

// File: rtl/airtime_chk.sv
module airtime_chk #(
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DUR_W-1:0] out_dur,
  input logic             div_busy,
  input logic             div_done
);
  // R9: the block only offers to take work when nothing is in flight
  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !div_busy && !div_done));

  // R9: divider completion is a single-cycle pulse that produces a result
  a_r9_done_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> (out_valid && !div_done));

  // R10: result held steady under back-pressure
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dur)));

  // R11: completed transfer frees the block
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  // R5: no frame is shorter than one OFDM symbol plus its header
  a_r5_min_duration: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dur >= DUR_W'(24)));
endmodule

bind airtime_calc airtime_chk #(.DUR_W(DUR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dur   (out_dur),
  .div_busy  (div_busy),
  .div_done  (div_done)
);

// File: tb/airtime_calc_tb.sv
module airtime_calc_tb;
  localparam int LEN_W = 12;
  localparam int DUR_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [LEN_W-1:0] in_len = '0;
  logic [3:0]       in_rate = '0;
  logic             in_short_pre = 1'b0;
  logic [1:0]       in_pkt = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [DUR_W-1:0] out_dur;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  airtime_calc #(.LEN_W(LEN_W), .DUR_W(DUR_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_len       (in_len),
    .in_rate      (in_rate),
    .in_short_pre (in_short_pre),
    .in_pkt       (in_pkt),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_dur      (out_dur)
  );

  function automatic int ref_dur(int len, int idx, int sp, int pt);
    int tbl [12] = '{10, 20, 55, 110, 24, 36, 48, 72, 96, 144, 192, 216};
    int i;
    int r;
    int n;
    i = (idx > 11) ? 11 : idx;
    r = tbl[i];
    if (i <= 3) begin
      n = (len * 80 + r - 1) / r;
      return ((sp != 0) ? 96 : 192) + n;
    end
    n = (len * 8 + 22 + r - 1) / r;
    return 20 + 4 * n + ((pt != 0) ? 6 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input int len, input int idx, input int sp, input int pt,
                         input string req, output int dur);
    int held;
    @(negedge clk);
    in_len = LEN_W'(len);
    in_rate = 4'(idx);
    in_short_pre = sp[0];
    in_pkt = 2'(pt);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk("R9 busy after accept", int'(in_ready), 0);
    // junk requests while busy must be ignored (R9)
    for (int k = 0; k < 4; k++) begin
      in_len = ~in_len;
      in_rate = 4'($urandom % 16);
      in_short_pre = ~in_short_pre;
      in_pkt = 2'($urandom % 3);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    dur = int'(out_dur);
    chk(req, dur, ref_dur(len, idx, sp, pt));
    held = int'(out_dur);
    repeat (2) @(negedge clk);
    chk("R10 valid held", int'(out_valid), 1);
    chk("R10 data held", int'(out_dur), held);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R11 valid drops", int'(out_valid), 0);
    chk("R11 ready returns", int'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a;
    int b;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0A17);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid reset", int'(out_valid), 0);
    chk("R1 in_ready reset", int'(in_ready), 1);

    // R3 directed CCK cases
    run_req(0, 0, 0, 1, "R3 zero length long", a);
    chk("R3 zero length value", a, 192);
    run_req(1, 2, 0, 1, "R3 5.5M round up", a);
    chk("R3 5.5M value", a, 194);
    run_req(4095, 0, 0, 1, "R3 max length 1M", a);
    chk("R3 max length value", a, 32952);
    // R4 exact division
    run_req(11, 3, 1, 1, "R4 exact 11M", a);
    chk("R4 exact value", a, 104);
    run_req(11, 2, 1, 1, "R4 exact 5.5M", a);
    chk("R4 exact 5.5M value", a, 96 + 16);
    // R5 and R6 OFDM
    run_req(100, 4, 0, 0, "R5 ofdm 6M", a);
    chk("R5 ofdm value", a, 160);
    run_req(100, 4, 0, 2, "R6 ofdm ext", b);
    chk("R6 ext difference", b - a, 6);
    run_req(0, 11, 0, 0, "R5 ofdm zero length", a);
    chk("R5 zero length value", a, 24);
    // R2 clamp
    run_req(1500, 11, 0, 0, "R2 index 11", a);
    for (int ix = 12; ix < 16; ix++) begin
      run_req(1500, ix, 0, 0, "R2 clamped index", b);
      chk("R2 clamp equals 11", b, a);
    end
    // R7 preamble flag no effect on OFDM
    run_req(777, 7, 0, 1, "R7 ofdm long flag", a);
    run_req(777, 7, 1, 1, "R7 ofdm short flag", b);
    chk("R7 flag ignored", b, a);
    // R8 packet code no effect on CCK
    run_req(333, 1, 1, 0, "R8 cck pkt0", a);
    run_req(333, 1, 1, 2, "R8 cck pkt2", b);
    chk("R8 pkt ignored", b, a);

    // random mix, checked against the reference model (R3 R5 R6)
    for (int t = 0; t < 60; t++) begin
      int len;
      int idx;
      int sp;
      int pt;
      len = int'($urandom % 4096);
      idx = int'($urandom % 16);
      sp  = int'($urandom % 2);
      pt  = int'($urandom % 3);
      run_req(len, idx, sp, pt, (idx <= 3) ? "R3 random cck" : "R5 R6 random ofdm", a);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule